// File: doc/BRIEF.md
# Audio Converter Clock Enable Tree

This block derives every internal timing strobe of an audio converter from a single master clock. Instead of producing new clocks, it emits single-cycle clock-enable pulses in the master clock domain. A system strobe `sys_ce` runs at the master rate or at half of it. Two programmable dividers hang off the system strobe, one for the ADC branch and one for the DAC branch. The ADC branch adds a fixed halving stage, so the divider produces a 256fs rate and the ADC itself is paced at 128fs.

There are two gates. The system gate stops the whole tree. The converter gate stops only the ADC and DAC branch, and the system strobe keeps running for peripheral logic. A disabled branch freezes its counters, and counting resumes from the frozen value when the branch is enabled again.

Software programs the block through a small register port. A new divider code or predivide choice is applied only when the affected counter reaches its terminal count, so a reprogramming never produces a shortened period.

Top module: `aclk_tree`

## Requirements
- R1: A synchronous active-high `rst` sets the following defaults: predivide select 0, system gate 1, converter gate 1, both divider codes 000. It also clears all counters. After reset, address 4 reads 0x00, address 8 reads 0x30 and address 6 reads 0x00.
- R2: The register map is as follows. Address 4 bit 2 is the predivide select. Address 8 bit 5 is the system gate and bit 4 is the converter gate. Address 6 bits [2:0] hold the ADC divider code and bits [5:3] hold the DAC divider code. Unused bits read 0, and other addresses read 0. A write to any other address changes no setting.
- R3: With predivide select 0, `sys_ce` is high on every cycle. With select 1, it is high on every second cycle.
- R4: Divider codes decode as 000 = /1, 010 = /2, 011 = /3, 100 = /4 and 110 = /6. Every other code acts as /1. `dac_ce` pulses once per N `sys_ce` pulses.
- R5: `adc_ce` pulses once per 2·N `sys_ce` pulses, where N is the ADC divider ratio. This is the 256fs divider followed by a fixed halving stage.
- R6: While the system gate is 0, `sys_ce`, `adc_ce` and `dac_ce` stay low and every counter holds its value. Counting resumes from that value when the gate returns to 1.
- R7: While the converter gate is 0, `adc_ce` and `dac_ce` stay low and their counters hold. `sys_ce` keeps its normal rate.
- R8: A changed divider code or predivide select takes effect only at the next terminal count of its counter. The period in progress completes at the old ratio.
- R9: Each strobe is high for single cycles only. `adc_ce` and `dac_ce` are never high in a cycle where `sys_ce` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address for write and read |
| cfg_wdata | input | 6 | Register write data |
| cfg_rdata | output | 6 | Read data for `cfg_addr` (combinational) |
| sys_ce | output | 1 | System rate enable strobe |
| adc_ce | output | 1 | ADC (128fs) enable strobe |
| dac_ce | output | 1 | DAC enable strobe |

## Verification
A register write can land on the same master clock edge on which a divider reaches its terminal count. In that case the counter must latch the ratio of the code in force before the edge, and the new code applies one full period later. The bench provokes this by sweeping the write instant across every phase of a /6 period, for both the converter dividers and the predivide select. A behavioural reference model predicts every strobe on every cycle, and any pulse that arrives early or is missing is reported against R8 or R4.

// File: rtl/aclk_pkg.sv
package aclk_pkg;

    localparam int ADDR_W = 4;
    localparam int DATA_W = 6;
    localparam int CODE_W = 3;
    localparam int CNT_W  = 3;

    localparam int NCONV   = 2;
    localparam int IDX_ADC = 0;
    localparam int IDX_DAC = 1;

    localparam logic [ADDR_W-1:0] A_SYS  = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] A_DIV  = ADDR_W'(6);
    localparam logic [ADDR_W-1:0] A_GATE = ADDR_W'(8);

    localparam int B_HALF  = 2;
    localparam int B_SEN   = 5;
    localparam int B_DEN   = 4;
    localparam int B_ACODE = 0;
    localparam int B_DCODE = 3;

    localparam logic [CNT_W-1:0] ONE_RATIO = CNT_W'(1);
    localparam logic [CNT_W-1:0] TWO_RATIO = CNT_W'(2);

    typedef enum logic [CODE_W-1:0] {
        DIV1 = 3'b000,
        DIV2 = 3'b010,
        DIV3 = 3'b011,
        DIV4 = 3'b100,
        DIV6 = 3'b110
    } div_code_e;

    typedef struct packed {
        logic              half;
        logic              sys_en;
        logic              dsp_en;
        logic [CODE_W-1:0] adc_code;
        logic [CODE_W-1:0] dac_code;
    } clk_cfg_t;

    localparam clk_cfg_t CFG_RESET = '{
        half:     1'b0,
        sys_en:   1'b1,
        dsp_en:   1'b1,
        adc_code: DIV1,
        dac_code: DIV1
    };

    function automatic logic [CNT_W-1:0] code_ratio(input logic [CODE_W-1:0] c);
        logic [CNT_W-1:0] r;
        case (div_code_e'(c))
            DIV2:    r = CNT_W'(2);
            DIV3:    r = CNT_W'(3);
            DIV4:    r = CNT_W'(4);
            DIV6:    r = CNT_W'(6);
            default: r = CNT_W'(1);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/aclk_cfg.sv
module aclk_cfg
    import aclk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output clk_cfg_t          cfg,
    output logic [DATA_W-1:0] rdata
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= CFG_RESET;
        end else if (we) begin
            case (addr)
                A_SYS:  cfg.half <= wdata[B_HALF];
                A_GATE: begin
                    cfg.sys_en <= wdata[B_SEN];
                    cfg.dsp_en <= wdata[B_DEN];
                end
                A_DIV: begin
                    cfg.adc_code <= wdata[B_ACODE +: CODE_W];
                    cfg.dac_code <= wdata[B_DCODE +: CODE_W];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_SYS:  rdata[B_HALF] = cfg.half;
            A_GATE: begin
                rdata[B_SEN] = cfg.sys_en;
                rdata[B_DEN] = cfg.dsp_en;
            end
            A_DIV: begin
                rdata[B_ACODE +: CODE_W] = cfg.adc_code;
                rdata[B_DCODE +: CODE_W] = cfg.dac_code;
            end
            default: ;
        endcase
    end

    // R1: reset loads every field to its default
    p_reset_defaults_r1: assert property (@(posedge clk)
        rst |=> (cfg == CFG_RESET));

    // R2: writes outside the map leave all settings untouched
    p_unmapped_ignored_r2: assert property (@(posedge clk) disable iff (rst)
        (we && addr != A_SYS && addr != A_DIV && addr != A_GATE) |=> $stable(cfg));

endmodule

// File: rtl/aclk_div.sv
module aclk_div
    import aclk_pkg::*;
#(
    parameter logic [CNT_W-1:0] RST_RATIO = ONE_RATIO
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic             gate,
    input  logic [CNT_W-1:0] ratio_next,
    output logic             ce
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] ratio_q;
    logic             last;
    logic             adv;

    assign last = (cnt_q == ratio_q - 1'b1);
    assign adv  = step && gate;
    assign ce   = adv && last;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            ratio_q <= RST_RATIO;
        end else if (adv) begin
            if (last) begin
                cnt_q   <= '0;
                ratio_q <= ratio_next;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R6, R7: a closed gate freezes the count
    p_hold_when_gated_r6: assert property (@(posedge clk) disable iff (rst)
        !gate |=> $stable(cnt_q));

    // R4: the count never leaves the current period
    p_count_in_range_r4: assert property (@(posedge clk) disable iff (rst)
        cnt_q < ratio_q);

    // R8: the ratio is only replaced on a terminal-count pulse
    p_ratio_latch_r8: assert property (@(posedge clk) disable iff (rst)
        !ce |=> $stable(ratio_q));

endmodule

// File: rtl/aclk_tree.sv
module aclk_tree
    import aclk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    output logic              sys_ce,
    output logic              adc_ce,
    output logic              dac_ce
);

    clk_cfg_t         cfg;
    logic [CNT_W-1:0] pre_ratio;
    logic [CODE_W-1:0] conv_code [NCONV];
    logic [NCONV-1:0] conv_ce;

    aclk_cfg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .cfg   (cfg),
        .rdata (cfg_rdata)
    );

    assign pre_ratio = cfg.half ? TWO_RATIO : ONE_RATIO;

    aclk_div #(.RST_RATIO(ONE_RATIO)) u_pre (
        .clk        (clk),
        .rst        (rst),
        .step       (1'b1),
        .gate       (cfg.sys_en),
        .ratio_next (pre_ratio),
        .ce         (sys_ce)
    );

    always_comb begin
        conv_code[IDX_ADC] = cfg.adc_code;
        conv_code[IDX_DAC] = cfg.dac_code;
    end

    for (genvar g = 0; g < NCONV; g++) begin : g_conv
        logic [CNT_W-1:0] rn;
        logic             base_ce;

        assign rn = code_ratio(conv_code[g]);

        aclk_div #(.RST_RATIO(ONE_RATIO)) u_div (
            .clk        (clk),
            .rst        (rst),
            .step       (sys_ce),
            .gate       (cfg.dsp_en),
            .ratio_next (rn),
            .ce         (base_ce)
        );

        if (g == IDX_ADC) begin : g_half
            aclk_div #(.RST_RATIO(TWO_RATIO)) u_half (
                .clk        (clk),
                .rst        (rst),
                .step       (base_ce),
                .gate       (cfg.dsp_en),
                .ratio_next (TWO_RATIO),
                .ce         (conv_ce[g])
            );

            // R5: every 128fs pulse falls on a 256fs pulse
            p_half_on_base_r5: assert property (@(posedge clk) disable iff (rst)
                conv_ce[g] |-> base_ce);
        end else begin : g_direct
            assign conv_ce[g] = base_ce;
        end
    end

    assign adc_ce = conv_ce[IDX_ADC];
    assign dac_ce = conv_ce[IDX_DAC];

    // R6: closed system gate silences the whole tree
    p_sys_gate_r6: assert property (@(posedge clk) disable iff (rst)
        !cfg.sys_en |-> !(sys_ce || adc_ce || dac_ce));

    // R7: closed converter gate silences only the converter strobes
    p_dsp_gate_r7: assert property (@(posedge clk) disable iff (rst)
        !cfg.dsp_en |-> !(adc_ce || dac_ce));

    // R9: converter strobes are a subset of system strobes
    p_subset_r9: assert property (@(posedge clk) disable iff (rst)
        (adc_ce || dac_ce) |-> sys_ce);

endmodule

// File: tb/test_aclk_tree.sv
module test_aclk_tree;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [3:0] cfg_addr = 4'd0;
    logic [5:0] cfg_wdata = 6'd0;
    logic [5:0] cfg_rdata;
    logic       sys_ce, adc_ce, dac_ce;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // reference model state
    int m_half, m_sen, m_den, m_acode, m_dcode;
    int pc, pr, ac, ar, dc, dr, hc;
    int n_sys, n_adc, n_dac;

    always #5 clk = ~clk;

    aclk_tree i_aclk_tree (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .sys_ce    (sys_ce),
        .adc_ce    (adc_ce),
        .dac_ce    (dac_ce)
    );

    function automatic int ratio_of(input int code);
        case (code)
            2: return 2;
            3: return 3;
            4: return 4;
            6: return 6;
            default: return 1;
        endcase
    endfunction

    function automatic int exp_rd(input int a);
        case (a)
            4: return m_half << 2;
            8: return (m_sen << 5) | (m_den << 4);
            6: return m_acode | (m_dcode << 3);
            default: return 0;
        endcase
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle reference comparison, then model step for the next edge
    always @(negedge clk) begin
        if (rst) begin
            m_half = 0; m_sen = 1; m_den = 1; m_acode = 0; m_dcode = 0;
            pc = 0; pr = 1; ac = 0; ar = 1; dc = 0; dr = 1; hc = 0;
        end else begin
            bit e_sys, e_a256, e_adc, e_dac;
            e_sys  = (m_sen != 0) && (pc == pr - 1);
            e_a256 = e_sys && (m_den != 0) && (ac == ar - 1);
            e_adc  = e_a256 && (hc == 1);
            e_dac  = e_sys && (m_den != 0) && (dc == dr - 1);
            chk("R3 sys_ce", int'(sys_ce), int'(e_sys));
            chk("R5 adc_ce", int'(adc_ce), int'(e_adc));
            chk("R4/R8 dac_ce", int'(dac_ce), int'(e_dac));
            chk("R9 subset", int'((adc_ce || dac_ce) && !sys_ce), 0);
            chk("R2 rdata", int'(cfg_rdata), exp_rd(int'(cfg_addr)));
            n_sys += int'(sys_ce); n_adc += int'(adc_ce); n_dac += int'(dac_ce);
            // R8: new ratios are picked up only when a period ends
            if (m_sen != 0) begin
                if (pc == pr - 1) begin pc = 0; pr = m_half ? 2 : 1; end
                else pc++;
            end
            if (e_sys && m_den != 0) begin
                if (ac == ar - 1) begin ac = 0; ar = ratio_of(m_acode); end else ac++;
                if (dc == dr - 1) begin dc = 0; dr = ratio_of(m_dcode); end else dc++;
            end
            if (e_a256) hc = 1 - hc;
            if (cfg_we) begin
                case (int'(cfg_addr))
                    4: m_half = int'(cfg_wdata[2]);
                    8: begin m_sen = int'(cfg_wdata[5]); m_den = int'(cfg_wdata[4]); end
                    6: begin m_acode = int'(cfg_wdata[2:0]); m_dcode = int'(cfg_wdata[5:3]); end
                    default: ;
                endcase
            end
        end
    end

    task automatic wr(input int a, input int d);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = 6'(d);
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic peek(input string tag, input int a, input int exp);
        cfg_addr = 4'(a);
        #1;
        chk(tag, int'(cfg_rdata), exp);
    endtask

    task automatic window(input int n);
        n_sys = 0; n_adc = 0; n_dac = 0;
        idle(n);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst = 1'b0;
        // R1 reset defaults
        peek("R1 reg4", 4, 0);
        peek("R1 reg8", 8, 'h30);
        peek("R1 reg6", 6, 0);

        // R3/R4/R5 default ratios
        window(12);
        chk("R3 default sys", n_sys, 12);
        chk("R4 default dac", n_dac, 12);
        chk("R5 default adc", n_adc, 6);

        // R3 predivide by two
        wr(4, 'h04); idle(4);
        window(20);
        chk("R3 half sys", n_sys, 10);
        wr(4, 'h00); idle(4);

        // R4/R5 every code, including reserved ones
        for (int c = 0; c < 8; c++) begin
            wr(6, (c << 3) | c); idle(20);
            window(24);
            chk("R4 code dac", n_dac, 24 / ratio_of(c));
            chk("R5 code adc", n_adc, 12 / ratio_of(c));
        end
        wr(6, 'h24); wr(4, 'h04); idle(20);
        window(48);
        chk("R4 half+div4 dac", n_dac, 6);
        chk("R5 half+div4 adc", n_adc, 3);
        wr(4, 'h00);

        // R8 reprogramming swept across every phase of a /6 period
        for (int off = 0; off < 7; off++) begin
            wr(6, 'h36); idle(15 + off);
            wr(6, 'h00); idle(3 + off);
            wr(4, 'h04); idle(off);
            wr(4, 'h00); idle(5);
        end

        // R6 system gate closed then reopened mid-period
        wr(6, 'h1B); wr(4, 'h04); idle(7);
        wr(8, 'h10); idle(2);
        window(20);
        chk("R6 sys gated", n_sys, 0);
        chk("R6 adc gated", n_adc, 0);
        chk("R6 dac gated", n_dac, 0);
        wr(8, 'h30); idle(30);
        wr(4, 'h00);

        // R7 converter gate closed
        wr(8, 'h20); idle(2);
        window(20);
        chk("R7 sys running", n_sys, 20);
        chk("R7 adc gated", n_adc, 0);
        chk("R7 dac gated", n_dac, 0);
        wr(8, 'h30); idle(20);

        // R2 unmapped write and unused bits
        wr(5, 'h3F);
        peek("R2 reg4 kept", 4, 0);
        peek("R2 reg6 kept", 6, 'h1B);
        peek("R2 reg8 kept", 8, 'h30);
        wr(8, 'h3F);
        peek("R2 reg8 unused bits", 8, 'h30);
        wr(4, 'h3F);
        peek("R2 reg4 unused bits", 4, 'h04);
        peek("R2 unmapped read", 5, 0);
        idle(10);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule